// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the four active-low PCI interrupt request pins of a bus segment and presents them as a 16-bit vector of legacy IRQ lines. Each PCI line has its own settings: a 4-bit target IRQ number, an enable, and a choice between level and edge delivery. Software loads these settings through a byte-wide write port. The routed vector goes to a legacy interrupt controller.

Every pin first passes through a two-flop synchronizer. It then drives a small per-line state machine with three states:
- `LN_IDLE`: the line is released.
- `LN_FIRE`: the first cycle after an assertion is seen.
- `LN_HOLD`: the line is still asserted after that first cycle.

The machine has these transitions:
- *arm*: `LN_IDLE` to `LN_FIRE` when the request is seen.
- *settle*: `LN_FIRE` to `LN_HOLD` while the request stays.
- *drop*: `LN_FIRE` or `LN_HOLD` to `LN_IDLE` when the request goes away.
- *wait*: `LN_IDLE` stays in `LN_IDLE` while there is no request.

In level mode a line contributes while its machine is in `LN_FIRE` or `LN_HOLD`. In edge mode it contributes only in `LN_FIRE`. The contributions of enabled lines are ORed into the bit their target selects. Some target numbers are reserved and are never driven.

Top module: `pirq_router`

## Requirements
- R1: After reset the vector `irq_o` is all zero, every line is disabled, every target is 0 and every line is in edge mode, so asserting a pin changes nothing until the block is configured.
- R2: A write to address 0 sets the INTA target from `cfg_wdata_i[7:4]` and the INTB target from `cfg_wdata_i[3:0]`. A write to address 1 sets INTC from `[7:4]` and INTD from `[3:0]`. Without a write these targets keep their value.
- R3: Address 2 holds the enables and address 3 holds the level-mode selects (1 = level, 0 = edge). In both, bit 0 is INTA, bit 1 is INTB, bit 2 is INTC and bit 3 is INTD. Bits 7:4 of those writes are ignored.
- R4: A pin counts as asserted when it is low. A low level sampled at a rising edge is first reflected in `irq_o` after the third rising edge, counting that one.
- R5: In level mode the target bit stays high for as long as the pin stays low. It falls after the third rising edge after the release is sampled.
- R6: In edge mode each assertion gives a pulse of exactly one cycle on the target bit. A pin held low gives no further pulse, and a new assertion gives a new pulse.
- R7: A disabled line never affects `irq_o`, whatever its pin, target or mode.
- R8: Enabled lines that share a target are ORed. The bit stays high while any of them contributes.
- R9: Target values 0, 1, 2, 8 and 13 are unrouted: those bits of `irq_o` are never driven. Targets 15 and the other values drive their own bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_n_i | input | 4 | PCI interrupt pins, active low; bit 0 INTA through bit 3 INTD |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| irq_o | output | 16 | Routed legacy IRQ vector, active high |

## Verification
The routing function is tried in several ways:
- Each line is asserted alone with four different targets. This separates the two nibbles and the four enable and mode bit positions from one another.
- Level and edge delivery are each tried with a long hold followed by a re-assertion. This tells a level follower from a single pulser and checks the synchronizer latency edge by edge.
- Two lines overlap on one target, and an enabled line runs beside a disabled one. These cases expose a wrong combine or a leaking enable.
- Every reserved target is programmed, and target 15 is used as the upper bound. This checks the unrouted set against a neighbour that must still be driven.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NUM_LINES = 4;
    localparam int TGT_W     = 4;
    localparam int IRQ_W     = 1 << TGT_W;
    localparam int CFG_AW    = 2;
    localparam int CFG_DW    = 8;

    localparam logic [CFG_AW-1:0] ADDR_ROUTE_AB = 2'd0;
    localparam logic [CFG_AW-1:0] ADDR_ROUTE_CD = 2'd1;
    localparam logic [CFG_AW-1:0] ADDR_ENABLE   = 2'd2;
    localparam logic [CFG_AW-1:0] ADDR_LEVEL    = 2'd3;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_FIRE = 2'd1,
        LN_HOLD = 2'd2
    } line_state_e;

    function automatic logic pirq_routable(input logic [TGT_W-1:0] tgt);
        logic ok;
        unique case (tgt)
            4'd0, 4'd1, 4'd2, 4'd8, 4'd13: ok = 1'b0;
            default:                       ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic [IRQ_W-1:0] pirq_unrouted_mask();
        logic [IRQ_W-1:0] m;
        m = '0;
        for (int i = 0; i < IRQ_W; i++) begin
            m[i] = !pirq_routable(TGT_W'(i));
        end
        return m;
    endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n_i,
    output logic [WIDTH-1:0] req_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= pin_n_i;
            stage2_q <= stage1_q;
        end
    end

    assign req_o = ~stage2_q;

    // R4: a synchronized request implies the pin was low two edges ago
    p_sync_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (req_o == ~$past(pin_n_i, 2)));

endmodule

// File: rtl/pirq_line_fsm.sv
module pirq_line_fsm
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic level_i,
    output logic act_o
);

    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: state_d = req_i ? LN_FIRE : LN_IDLE;
            LN_FIRE: state_d = req_i ? LN_HOLD : LN_IDLE;
            LN_HOLD: state_d = req_i ? LN_HOLD : LN_IDLE;
            default: state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LN_FIRE: act_o = 1'b1;
            LN_HOLD: act_o = level_i;
            default: act_o = 1'b0;
        endcase
    end

    // R6: the pulse state is only entered from the released state
    p_fire_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_FIRE) |-> ($past(state_q) == LN_IDLE));

    // R6: the pulse state never lasts two cycles
    p_fire_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_FIRE) |=> (state_q != LN_FIRE));

    // R5: a released request returns the line to idle on the next edge
    p_release_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (state_q == LN_IDLE));

endmodule

// File: rtl/pirq_cfg.sv
module pirq_cfg
    import pirq_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [CFG_AW-1:0]                 addr_i,
    input  logic [CFG_DW-1:0]                 wdata_i,
    output logic [NUM_LINES-1:0][TGT_W-1:0]   tgt_o,
    output logic [NUM_LINES-1:0]              en_o,
    output logic [NUM_LINES-1:0]              level_o
);

    logic [NUM_LINES-1:0][TGT_W-1:0] tgt_q;
    logic [NUM_LINES-1:0]            en_q;
    logic [NUM_LINES-1:0]            level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            en_q    <= '0;
            level_q <= '0;
        end else if (we_i) begin
            unique case (addr_i)
                ADDR_ROUTE_AB: begin
                    tgt_q[0] <= wdata_i[7:4];
                    tgt_q[1] <= wdata_i[3:0];
                end
                ADDR_ROUTE_CD: begin
                    tgt_q[2] <= wdata_i[7:4];
                    tgt_q[3] <= wdata_i[3:0];
                end
                ADDR_ENABLE:   en_q    <= wdata_i[NUM_LINES-1:0];
                ADDR_LEVEL:    level_q <= wdata_i[NUM_LINES-1:0];
                default: ;
            endcase
        end
    end

    assign tgt_o   = tgt_q;
    assign en_o    = en_q;
    assign level_o = level_q;

    // R2: targets only move on a write
    p_tgt_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(tgt_q));

    // R3: enables and modes only move on a write
    p_bits_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(en_q) && $stable(level_q)));

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           pirq_n_i,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_addr_i,
    input  logic [7:0]           cfg_wdata_i,
    output logic [15:0]          irq_o
);

    localparam logic [IRQ_W-1:0] UNROUTED = pirq_unrouted_mask();

    logic [NUM_LINES-1:0]            req;
    logic [NUM_LINES-1:0]            act;
    logic [NUM_LINES-1:0][TGT_W-1:0] tgt;
    logic [NUM_LINES-1:0]            en;
    logic [NUM_LINES-1:0]            level;
    logic [IRQ_W-1:0]                vec;

    pirq_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (pirq_n_i),
        .req_o   (req)
    );

    pirq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .tgt_o   (tgt),
        .en_o    (en),
        .level_o (level)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        pirq_line_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req[l]),
            .level_i (level[l]),
            .act_o   (act[l])
        );
    end

    always_comb begin
        vec = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (en[l] && act[l] && pirq_routable(tgt[l])) begin
                vec[tgt[l]] = 1'b1;
            end
        end
    end

    assign irq_o = vec;

    // R9: reserved IRQ numbers are never driven
    p_unrouted_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & UNROUTED) == '0);

    // R7: with every line disabled nothing reaches the vector
    p_disabled_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (irq_o == '0));

    // R1: the cycle after reset the vector is clear
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pirq_n = 4'hF;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pirq_router u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pirq_n_i    (pirq_n),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .irq_o       (irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic quiet();
        pirq_n = 4'hF;
        edges(4);
    endtask

    task automatic t_reset();
        chk(irq, 16'h0, "R1 reset vector");
        pirq_n = 4'h0;
        edges(5);
        chk(irq, 16'h0, "R1 unconfigured lines silent");
        quiet();
    endtask

    task automatic t_layout();
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h9A);
        wr(2'd2, 8'h0F);
        wr(2'd3, 8'h0F);
        for (int l = 0; l < 4; l++) begin
            logic [3:0] t;
            t = (l == 0) ? 4'd3 : (l == 1) ? 4'd4 : (l == 2) ? 4'd9 : 4'd10;
            pirq_n = ~(4'b1 << l);
            edges(3);
            chk(irq, 16'b1 << t, "R2 R3 nibble and bit order");
            quiet();
        end
    endtask

    task automatic t_level();
        pirq_n = 4'b1101;
        edges(2);
        chk(irq, 16'h0, "R4 not yet after two edges");
        edges(1);
        chk(irq, 16'h0010, "R4 visible after third edge");
        edges(10);
        chk(irq, 16'h0010, "R5 level held");
        pirq_n = 4'hF;
        edges(2);
        chk(irq, 16'h0010, "R5 still high two edges after release");
        edges(1);
        chk(irq, 16'h0, "R5 low after third edge");
        edges(2);
    endtask

    task automatic t_edge();
        wr(2'd3, 8'hF0);
        pirq_n = 4'b1110;
        edges(3);
        chk(irq, 16'h0008, "R6 pulse");
        edges(1);
        chk(irq, 16'h0, "R6 pulse lasts one cycle");
        edges(10);
        chk(irq, 16'h0, "R6 no repeat while held");
        pirq_n = 4'hF;
        edges(4);
        pirq_n = 4'b1110;
        edges(3);
        chk(irq, 16'h0008, "R6 new pulse on re-assertion");
        quiet();
    endtask

    task automatic t_disabled();
        wr(2'd3, 8'h0F);
        wr(2'd2, 8'hF0);
        pirq_n = 4'h0;
        edges(4);
        chk(irq, 16'h0, "R3 R7 upper enable bits ignored");
        wr(2'd2, 8'h0E);
        edges(1);
        chk(irq, 16'h0610, "R7 only enabled lines");
        quiet();
    endtask

    task automatic t_shared();
        wr(2'd0, 8'hBB);
        wr(2'd1, 8'hBB);
        wr(2'd2, 8'h0F);
        pirq_n = 4'b1010;
        edges(3);
        chk(irq, 16'h0800, "R8 shared target");
        pirq_n = 4'b1011;
        edges(6);
        chk(irq, 16'h0800, "R8 held by the other line");
        pirq_n = 4'hF;
        edges(3);
        chk(irq, 16'h0, "R8 low once all released");
        edges(2);
    endtask

    task automatic t_unrouted();
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h28);
        pirq_n = 4'h0;
        edges(4);
        chk(irq, 16'h0, "R9 targets 0 1 2 8 silent");
        wr(2'd1, 8'hD8);
        edges(1);
        chk(irq, 16'h0, "R9 target 13 silent");
        wr(2'd0, 8'hF1);
        edges(1);
        chk(irq, 16'h8000, "R9 target 15 driven");
        quiet();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_layout();
        t_level();
        t_edge();
        t_disabled();
        t_shared();
        t_unrouted();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule